// File: doc/BRIEF.md
# Grouped Channel Output Disable

This block sits between the output drivers of a bank of timer channels and the device pins. It gives an emergency shut-off path: a small set of external disable lines each governs one group of eight adjacent channels. When a group's disable line is active, every channel in that group that has been armed by software drives its pin to its inactive level. Unarmed channels keep following their generated waveform. The waveform generation itself is outside this block.

Each channel has two configuration bits, written through a plain address/data/strobe port. The first is an arm bit that makes the channel respond to its group's disable line. The second is a polarity bit that gives the channel's active level; the forced level is its complement. The disable lines are asynchronous to the block's clock. They pass through a synchronizer and then through a small two-state machine per group. The group state is PASS or KILL. The transition named "trip" goes from PASS to KILL when the synchronized line is high. The transition named "release" goes from KILL to PASS when it is low. Neither state holds on to a past disable. With the default of four groups the block covers 32 channels. Setting eight groups covers 64 channels with the same eight-channel grouping.

Top module: `grp_out_disable`

## Requirements
- R1: After reset all arm and polarity bits are 0 and every group is in PASS, so every pin equals its channel output.
- R2: Disable line g governs exactly channels 8g to 8g+7 (line 0: 0–7, line 1: 8–15, line 2: 16–23, line 3: 24–31).
- R3: A forced channel drives its pin to the complement of its polarity bit.
- R4: A channel whose arm bit is 0 is never affected by any disable line.
- R5: A disable line sampled high at clock edge k forces its group's armed pins from edge k+2 onward: two synchronizer edges, then the trip into KILL.
- R6: Release follows the same three-edge latency with no latching. A disable that is high at exactly one sampling edge forces pins for exactly one cycle.
- R7: A pin that is not forced equals its channel output in the same cycle, with no register delay.
- R8: A write with wr_en high stores wr_data[0] as the arm bit and wr_data[1] as the polarity bit of channel wr_addr. The write takes effect from the next edge and leaves all other channels unchanged.
- R9: Groups are independent. Any combination of disable lines forces only the armed channels of the active groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_out | input | 32 | Generated channel output values |
| dis_in | input | 4 | Asynchronous active-high group disable lines |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Channel index for the write |
| wr_data | input | 2 | Bit 0 arm, bit 1 polarity |
| pin | output | 32 | Values driven to the pins |

## Verification
The bench pins down the three-edge latency on both trip and release. An extra or missing pipeline stage would show forcing one cycle early or late. A one-cycle disable pulse exposes any design that latches the disable or stretches it. Each group is activated alone, so a wrong channel-to-group mapping shows up as the wrong byte of pins being forced. The bench runs with mixed arm and polarity patterns. An inverted forced level, or an unarmed channel that still obeys its group, then shows up as a pin mismatch.

// File: rtl/god_pkg.sv
package god_pkg;

    // Per-group disable state
    typedef enum logic {
        GRP_PASS = 1'b0,
        GRP_KILL = 1'b1
    } grp_state_e;

    // Configuration word field positions (decoded by the register file)
    localparam int CFG_W       = 2;
    localparam int CFG_ARM_BIT = 0;
    localparam int CFG_POL_BIT = 1;

    typedef struct packed {
        logic pol;
        logic arm;
    } ch_cfg_t;

endpackage

// File: rtl/god_sync.sv
module god_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/god_cfg_regs.sv
module god_cfg_regs
    import god_pkg::*;
#(
    parameter int NUM_CH = 32,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] arm,
    output logic [NUM_CH-1:0] pol
);

    ch_cfg_t cfg_q [NUM_CH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                cfg_q[i] <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    cfg_q[i].arm <= wr_data[CFG_ARM_BIT];
                    cfg_q[i].pol <= wr_data[CFG_POL_BIT];
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        assign arm[i] = cfg_q[i].arm;
        assign pol[i] = cfg_q[i].pol;
    end

endmodule

// File: rtl/god_group_fsm.sv
module god_group_fsm
    import god_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_req,
    output logic kill
);

    grp_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GRP_PASS;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: trip (PASS->KILL), release (KILL->PASS)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GRP_PASS: if (trip_req)  state_d = GRP_KILL;
            GRP_KILL: if (!trip_req) state_d = GRP_PASS;
            default:  state_d = GRP_PASS;
        endcase
    end

    // Outputs
    always_comb begin
        kill = (state_q == GRP_KILL);
    end

endmodule

// File: rtl/god_pin_mux.sv
module god_pin_mux #(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_SIZE = 8,
    localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE
) (
    input  logic [NUM_CH-1:0]     ch_out,
    input  logic [NUM_GROUPS-1:0] kill,
    input  logic [NUM_CH-1:0]     arm,
    input  logic [NUM_CH-1:0]     pol,
    output logic [NUM_CH-1:0]     pin
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GRP = i / GROUP_SIZE;
        logic forced;
        assign forced = kill[GRP] & arm[i];
        assign pin[i] = forced ? ~pol[i] : ch_out[i];
    end

endmodule

// File: rtl/grp_out_disable.sv
module grp_out_disable
    import god_pkg::*;
#(
    parameter int NUM_GROUPS  = 4,
    parameter int GROUP_SIZE  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     ch_out,
    input  logic [NUM_GROUPS-1:0] dis_in,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CFG_W-1:0]      wr_data,
    output logic [NUM_CH-1:0]     pin
);

    logic [NUM_GROUPS-1:0] dis_sync;
    logic [NUM_GROUPS-1:0] grp_kill;
    logic [NUM_CH-1:0]     cfg_arm;
    logic [NUM_CH-1:0]     cfg_pol;

    god_sync #(
        .W      (NUM_GROUPS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dis_in),
        .q     (dis_sync)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        god_group_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .trip_req (dis_sync[g]),
            .kill     (grp_kill[g])
        );
    end

    god_cfg_regs #(
        .NUM_CH (NUM_CH)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .arm     (cfg_arm),
        .pol     (cfg_pol)
    );

    god_pin_mux #(
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SIZE (GROUP_SIZE)
    ) u_mux (
        .ch_out (ch_out),
        .kill   (grp_kill),
        .arm    (cfg_arm),
        .pol    (cfg_pol),
        .pin    (pin)
    );

endmodule

// File: rtl/god_chk.sv
module god_chk
    import god_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int GROUP_SIZE = 8,
    localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_CH-1:0]     ch_out,
    input logic [NUM_CH-1:0]     pin,
    input logic [NUM_GROUPS-1:0] dis_sync,
    input logic [NUM_GROUPS-1:0] kill,
    input logic [NUM_CH-1:0]     arm,
    input logic [NUM_CH-1:0]     pol,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [CFG_W-1:0]      wr_data
);

    AST_TRIP_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> kill == $past(dis_sync)); // R5

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int GRP = i / GROUP_SIZE;

        AST_FORCED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (kill[GRP] && arm[i]) |-> pin[i] == ~pol[i]); // R3

        AST_UNARMED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            !arm[i] |-> pin[i] == ch_out[i]); // R4

        AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
            !kill[GRP] |-> pin[i] == ch_out[i]); // R7

        AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(i)) |=>
                (arm[i] == $past(wr_data[CFG_ARM_BIT]) &&
                 pol[i] == $past(wr_data[CFG_POL_BIT]))); // R8

        AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_addr == ADDR_W'(i)) |=> $stable(arm[i]) && $stable(pol[i])); // R8
    end

endmodule

bind grp_out_disable god_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_SIZE (GROUP_SIZE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_out   (ch_out),
    .pin      (pin),
    .dis_sync (dis_sync),
    .kill     (grp_kill),
    .arm      (cfg_arm),
    .pol      (cfg_pol),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/tb_grp_out_disable.sv
`timescale 1ns/1ps
module tb_grp_out_disable;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ch_out = '0;
    logic [3:0]  dis_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [1:0]  wr_data = '0;
    logic [31:0] pin;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk; // 250 MHz

    grp_out_disable dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_out  (ch_out),
        .dis_in  (dis_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pin     (pin)
    );

    // Behavioural reference: history of sampled disable lines and config bits
    logic [3:0]  hist[$];
    logic [31:0] m_arm = '0;
    logic [31:0] m_pol = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist.delete();
            m_arm = '0;
            m_pol = '0;
        end else begin
            hist.push_front(dis_in);
            if (hist.size() > 3) void'(hist.pop_back());
            if (wr_en) begin
                m_arm[wr_addr] = wr_data[0];
                m_pol[wr_addr] = wr_data[1];
            end
        end
    end

    function automatic logic [31:0] model_pins();
        logic [31:0] r;
        logic [3:0]  act;
        act = (hist.size() == 3) ? hist[2] : 4'h0;
        for (int i = 0; i < 32; i++) begin
            if (act[i/8] && m_arm[i]) r[i] = ~m_pol[i];
            else                      r[i] = ch_out[i];
        end
        return r;
    endfunction

    task automatic tick(input string tag);
        logic [31:0] e;
        @(negedge clk);
        e = model_pins();
        n_chk++;
        if (pin !== e) begin
            n_fail++;
            $display("FAIL %s: pin=%h expected=%h", tag, pin, e);
        end
    endtask

    task automatic tick_exp(input string tag, input logic [31:0] e);
        tick(tag);
        n_chk++;
        if (pin !== e) begin
            n_fail++;
            $display("FAIL %s (fixed): pin=%h expected=%h", tag, pin, e);
        end
    endtask

    task automatic wr_ch(input string tag, input int ch, input logic arm, input logic pl);
        wr_en   = 1'b1;
        wr_addr = 5'(ch);
        wr_data = {pl, arm};
        tick(tag);
        wr_en   = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: pin=%h expected=completion", pin);
        finish_run();
    end

    initial begin
        // R1: reset state, pins follow channel outputs
        for (int k = 0; k < 4; k++) begin
            ch_out = $urandom;
            dis_in = 4'hF;
            tick_exp("R1", ch_out);
        end
        @(negedge clk);
        dis_in = 4'h0;
        rst_n  = 1'b1;
        for (int k = 0; k < 3; k++) begin
            ch_out = $urandom;
            tick_exp("R1", ch_out);
        end

        // R8: arm everything, polarity 0; force lines idle
        ch_out = 32'h0;
        for (int c = 0; c < 32; c++) wr_ch("R8", c, 1'b1, 1'b0);
        tick_exp("R8", 32'h0);

        // R5: hold all lines high, forced from third sampling edge
        dis_in = 4'hF;
        tick_exp("R5", 32'h0);
        tick_exp("R5", 32'h0);
        tick_exp("R5", 32'hFFFF_FFFF);
        tick_exp("R5", 32'hFFFF_FFFF);
        // R6: release with same latency
        dis_in = 4'h0;
        tick_exp("R6", 32'hFFFF_FFFF);
        tick_exp("R6", 32'hFFFF_FFFF);
        tick_exp("R6", 32'h0);
        // R6: one-cycle pulse forces exactly one cycle
        dis_in = 4'hF;
        tick_exp("R6", 32'h0);
        dis_in = 4'h0;
        tick_exp("R6", 32'h0);
        tick_exp("R6", 32'hFFFF_FFFF);
        tick_exp("R6", 32'h0);
        tick_exp("R6", 32'h0);

        // R2: each group alone, arm all, polarity 0, outputs low
        for (int g = 0; g < 4; g++) begin
            dis_in = 4'(1 << g);
            tick("R2"); tick("R2");
            tick_exp("R2", 32'hFF << (8 * g));
            dis_in = 4'h0;
            tick("R2"); tick("R2");
            tick_exp("R2", 32'h0);
        end

        // R3: polarity 1 forces low while outputs are high
        ch_out = 32'hFFFF_FFFF;
        for (int c = 0; c < 32; c++) wr_ch("R3", c, 1'b1, 1'b1);
        dis_in = 4'hF;
        tick("R3"); tick("R3");
        tick_exp("R3", 32'h0);
        dis_in = 4'h0;
        tick("R3"); tick("R3");
        tick_exp("R3", 32'hFFFF_FFFF);

        // R4: unarmed odd channels ignore disable, mixed polarity
        for (int c = 0; c < 32; c++) wr_ch("R4", c, (c % 2) == 0, (c % 4) == 0);
        ch_out = 32'hA5A5_5A5A;
        dis_in = 4'hF;
        tick("R4"); tick("R4");
        // even channels forced to ~pol: c%4==0 -> 0, c%4==2 -> 1; odd follow ch_out
        tick_exp("R4", (32'hA5A5_5A5A & 32'hAAAA_AAAA) | 32'h4444_4444);
        for (int k = 0; k < 6; k++) begin
            ch_out = $urandom;
            tick("R4");
        end
        dis_in = 4'h0;

        // R7/R9: random outputs, lines, configuration writes
        for (int k = 0; k < 400; k++) begin
            ch_out = $urandom;
            if ((k % 5) == 0) dis_in = 4'($urandom);
            if (($urandom % 4) == 0) begin
                wr_en   = 1'b1;
                wr_addr = 5'($urandom);
                wr_data = 2'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            tick((k % 2) ? "R9" : "R7");
        end
        wr_en = 1'b0;

        // R7: lines idle, pins match outputs in the same cycle
        dis_in = 4'h0;
        tick("R7"); tick("R7"); tick("R7");
        for (int k = 0; k < 8; k++) begin
            ch_out = $urandom;
            tick_exp("R7", ch_out);
        end

        finish_run();
    end

endmodule